// File: doc/BRIEF.md
# Throttle Ratio Search Engine

This block picks the ON and OFF interval counts for a clock-suspend modulator so that the average processor speed comes as close as possible to a requested frequency. Software or a power controller gives it the full-speed frequency, the wanted frequency and a limit on the total modulation period, then pulses `start`. The engine tries every candidate period length, starting at the limit and working down to one interval. For each one it computes the OFF count, the ON count and the speed that pair would give, and it keeps the best pair.

Both divisions per candidate run on one shared restoring divider, one quotient bit per cycle. When the search ends the engine presents the chosen counts, the speed they give and a flag telling the modulator to switch off, and it pulses `done` for one cycle. If the best speed it found is full speed, modulation is not worth using: the flag is raised and both counts read zero.

Top module: `throttle_ratio_search`

## Requirements
- R1: After reset `done`, `mod_disable`, `on_cnt`, `off_cnt` and `achieved_khz` are all zero.
- R2: The period limit is sampled on `start`. A value of 0 selects 255, a value above 255 is clipped to 255, and any value from 1 to 255 is used as given.
- R3: For a candidate period i, OFF = floor(target·i / full) kept to its low 8 bits, ON = (i − OFF) mod 256, and the candidate speed = floor(full·OFF / i). Targets above full speed are accepted and follow the same truncation.
- R4: Candidates are tried from the limit down to 1. A candidate replaces the current best when its absolute error |speed − target| is less than or equal to the best error, so on a tie the shorter period wins.
- R5: Before the first candidate the best result is full speed with OFF = 1 and ON = 0.
- R6: When the chosen speed equals full speed, `mod_disable` is 1, both counts are 0 and `achieved_khz` equals full speed. Otherwise `mod_disable` is 0 and the outputs carry the chosen pair and its speed.
- R7: `done` is high for exactly one cycle per search. The result outputs change only in that cycle and hold until the next `done`.
- R8: A `start` that arrives while a search is running is ignored, and the running search completes on its original inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; inputs sampled in this cycle |
| full_khz | input | 32 | Full-speed frequency in kHz (nonzero) |
| target_khz | input | 32 | Requested frequency in kHz |
| period_limit | input | 16 | Maximum total period in intervals (0 means 255) |
| done | output | 1 | One-cycle pulse when results are valid |
| on_cnt | output | 8 | Chosen suspended-interval count |
| off_cnt | output | 8 | Chosen running-interval count |
| achieved_khz | output | 40 | Speed produced by the chosen pair |
| mod_disable | output | 1 | Modulation should be switched off |

## Verification
The tie rule gets the most attention. A half-speed target gives an exact match at every even period, so an engine that searched upward, or used strict less-than, would return a long period such as 10/10 where the shortest, 1/1, is required. Targets just under full speed make every candidate worse than the starting point, and an engine with the wrong initial best would return a real pair where it must report that modulation is off. Period limits of 0 and above 255, targets above full speed (OFF truncated to 8 bits) and a second `start` issued mid-search are also driven. Each exposes a bad clip, a wrong truncation or a search that restarts, because the counts differ from those the bench computes on its own.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOFF,
    S_WOFF,
    S_LACH,
    S_WACH,
    S_FIN
  } srch_state_t;
endpackage

// File: rtl/thr_divider.sv
// Restoring divider, one quotient bit per cycle; ready pulses with the result.
module thr_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         ready,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;

  assign shifted = {rem_q, quotient[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, dsr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      dsr_q    <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      ready    <= 1'b0;
      quotient <= '0;
    end else begin
      ready <= 1'b0;
      if (go) begin
        rem_q    <= '0;
        quotient <= dividend;
        dsr_q    <= divisor;
        cnt_q    <= CW'(W);
        run_q    <= 1'b1;
      end else if (run_q) begin
        if (!trial[W+1]) begin
          rem_q    <= trial[W-1:0];
          quotient <= {quotient[W-2:0], 1'b1};
        end else begin
          rem_q    <= shifted[W-1:0];
          quotient <= {quotient[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thr_best_track.sv
// Holds the best candidate so far; later candidates win ties.
module thr_best_track #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8,
  parameter int ACH_W  = FREQ_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [FREQ_W-1:0] init_full,
  input  logic              upd,
  input  logic [CNT_W-1:0]  cand_on,
  input  logic [CNT_W-1:0]  cand_off,
  input  logic [ACH_W-1:0]  cand_ach,
  input  logic [FREQ_W-1:0] target,
  output logic [CNT_W-1:0]  best_on,
  output logic [CNT_W-1:0]  best_off,
  output logic [ACH_W-1:0]  best_ach
);
  logic [ACH_W-1:0] tgt_w, cand_err, best_err;

  assign tgt_w    = ACH_W'(target);
  assign cand_err = (cand_ach >= tgt_w) ? cand_ach - tgt_w : tgt_w - cand_ach;
  assign best_err = (best_ach >= tgt_w) ? best_ach - tgt_w : tgt_w - best_ach;

  always_ff @(posedge clk) begin
    if (rst) begin
      best_on  <= '0;
      best_off <= '0;
      best_ach <= '0;
    end else if (init) begin
      best_on  <= '0;
      best_off <= CNT_W'(1);
      best_ach <= ACH_W'(init_full);
    end else if (upd && (cand_err <= best_err)) begin
      best_on  <= cand_on;
      best_off <= cand_off;
      best_ach <= cand_ach;
    end
  end
endmodule

// File: rtl/throttle_ratio_search.sv
module throttle_ratio_search #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8,
  parameter int LIM_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [FREQ_W-1:0]         full_khz,
  input  logic [FREQ_W-1:0]         target_khz,
  input  logic [LIM_W-1:0]          period_limit,
  output logic                      done,
  output logic [CNT_W-1:0]          on_cnt,
  output logic [CNT_W-1:0]          off_cnt,
  output logic [FREQ_W+CNT_W-1:0]   achieved_khz,
  output logic                      mod_disable
);
  import thr_pkg::*;

  localparam int ACH_W      = FREQ_W + CNT_W;
  localparam int MAX_PERIOD = (1 << CNT_W) - 1;

  srch_state_t       state_q;
  logic [FREQ_W-1:0] full_q, tgt_q;
  logic [CNT_W-1:0]  i_q, cand_on_q, cand_off_q, lim_eff;
  logic              searching;
  logic              div_go, div_ready, upd;
  logic [ACH_W-1:0]  div_dvd, div_dsr, div_quo;
  logic [CNT_W-1:0]  best_on, best_off;
  logic [ACH_W-1:0]  best_ach;
  logic              init;

  assign lim_eff = ((period_limit == '0) || (period_limit > LIM_W'(MAX_PERIOD)))
                   ? CNT_W'(MAX_PERIOD) : period_limit[CNT_W-1:0];

  assign searching = (state_q != S_IDLE);
  assign init      = (state_q == S_IDLE) && start;
  assign div_go    = (state_q == S_LOFF) || (state_q == S_LACH);
  assign upd       = (state_q == S_WACH) && div_ready;

  always_comb begin
    if (state_q == S_LACH) begin
      div_dvd = ACH_W'(full_q) * ACH_W'(cand_off_q);
      div_dsr = ACH_W'(i_q);
    end else begin
      div_dvd = ACH_W'(tgt_q) * ACH_W'(i_q);
      div_dsr = ACH_W'(full_q);
    end
  end

  thr_divider #(.W(ACH_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dsr),
    .ready    (div_ready),
    .quotient (div_quo)
  );

  thr_best_track #(.FREQ_W(FREQ_W), .CNT_W(CNT_W), .ACH_W(ACH_W)) u_best (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .init_full (full_khz),
    .upd       (upd),
    .cand_on   (cand_on_q),
    .cand_off  (cand_off_q),
    .cand_ach  (div_quo),
    .target    (tgt_q),
    .best_on   (best_on),
    .best_off  (best_off),
    .best_ach  (best_ach)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      full_q       <= '0;
      tgt_q        <= '0;
      i_q          <= '0;
      cand_on_q    <= '0;
      cand_off_q   <= '0;
      done         <= 1'b0;
      on_cnt       <= '0;
      off_cnt      <= '0;
      achieved_khz <= '0;
      mod_disable  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          full_q  <= full_khz;
          tgt_q   <= target_khz;
          i_q     <= lim_eff;
          state_q <= S_LOFF;
        end
        S_LOFF: state_q <= S_WOFF;
        S_WOFF: if (div_ready) begin
          cand_off_q <= div_quo[CNT_W-1:0];
          cand_on_q  <= i_q - div_quo[CNT_W-1:0];
          state_q    <= S_LACH;
        end
        S_LACH: state_q <= S_WACH;
        S_WACH: if (div_ready) begin
          if (i_q == CNT_W'(1)) begin
            state_q <= S_FIN;
          end else begin
            i_q     <= i_q - 1'b1;
            state_q <= S_LOFF;
          end
        end
        S_FIN: begin
          done         <= 1'b1;
          achieved_khz <= best_ach;
          if (best_ach == ACH_W'(full_q)) begin
            mod_disable <= 1'b1;
            on_cnt      <= '0;
            off_cnt     <= '0;
          end else begin
            mod_disable <= 1'b0;
            on_cnt      <= best_on;
            off_cnt     <= best_off;
          end
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thr_search_checker.sv
module thr_search_checker #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    searching,
  input logic [FREQ_W-1:0]       tgt_q,
  input logic [FREQ_W-1:0]       full_q,
  input logic                    done,
  input logic [CNT_W-1:0]        on_cnt,
  input logic [CNT_W-1:0]        off_cnt,
  input logic [FREQ_W+CNT_W-1:0] achieved_khz,
  input logic                    mod_disable
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(on_cnt) && $stable(off_cnt) && $stable(achieved_khz)
               && $stable(mod_disable)));

  assert_disable_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (done && mod_disable) |-> (on_cnt == '0 && off_cnt == '0
                               && achieved_khz == (FREQ_W+CNT_W)'(full_q)));

  assert_active_not_full_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !mod_disable) |-> (achieved_khz != (FREQ_W+CNT_W)'(full_q)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (searching && start) |=> $stable(tgt_q));
endmodule

bind throttle_ratio_search thr_search_checker #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .searching    (searching),
  .tgt_q        (tgt_q),
  .full_q       (full_q),
  .done         (done),
  .on_cnt       (on_cnt),
  .off_cnt      (off_cnt),
  .achieved_khz (achieved_khz),
  .mod_disable  (mod_disable)
);

// File: tb/throttle_ratio_search_test.sv
`timescale 1ns/1ps
module throttle_ratio_search_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] full_khz = '0, target_khz = '0;
  logic [15:0] period_limit = '0;
  logic        done, mod_disable;
  logic [7:0]  on_cnt, off_cnt;
  logic [39:0] achieved_khz;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  throttle_ratio_search uut (
    .clk(clk), .rst(rst), .start(start), .full_khz(full_khz),
    .target_khz(target_khz), .period_limit(period_limit), .done(done),
    .on_cnt(on_cnt), .off_cnt(off_cnt), .achieved_khz(achieved_khz),
    .mod_disable(mod_disable));

  // full, target, limit
  localparam logic [95:0] VECS [9] = '{
    {32'd200000, 32'd100000, 32'd20},    // R4 tie toward short period
    {32'd200000, 32'd50000,  32'd16},
    {32'd233000, 32'd77777,  32'd30},
    {32'd100000, 32'd99999,  32'd12},    // R5 initial best survives
    {32'd300000, 32'd1000,   32'd8},
    {32'd50000,  32'd80000,  32'd10},    // R3 target above full
    {32'd200000, 32'd200000, 32'd255},   // R6 full speed
    {32'd123456, 32'd65432,  32'd0},     // R2 zero means 255
    {32'd200000, 32'd150000, 32'd300}    // R2 clip to 255
  };

  longint e_on, e_off, e_ach;
  bit     e_dis;

  task automatic model(input longint f, input longint t, input longint lim_in);
    longint lim, b_on, b_off, b_ach, off, on, ach, ce, be;
    lim = (lim_in == 0 || lim_in > 255) ? 255 : lim_in;
    b_on = 0; b_off = 1; b_ach = f;
    for (longint i = lim; i >= 1; i--) begin
      off = ((t * i) / f) & 255;
      on  = (i - off) & 255;
      ach = (f * off) / i;
      ce = (ach > t) ? ach - t : t - ach;
      be = (b_ach > t) ? b_ach - t : t - b_ach;
      if (ce <= be) begin b_on = on; b_off = off; b_ach = ach; end
    end
    e_dis = (b_ach == f);
    e_on  = e_dis ? 0 : b_on;
    e_off = e_dis ? 0 : b_off;
    e_ach = b_ach;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] f, input logic [31:0] t, input logic [15:0] l);
    @(negedge clk);
    full_khz = f; target_khz = t; period_limit = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int c = 0;
    while (!done && c < 40000) begin @(negedge clk); c++; end
    chk(req, "done seen", longint'(done), 1);
  endtask

  task automatic check_result(input string req);
    chk(req, "on_cnt", on_cnt, e_on);
    chk(req, "off_cnt", off_cnt, e_off);
    chk(req, "achieved", achieved_khz, e_ach);
    chk(req, "disable", longint'(mod_disable), longint'(e_dis));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", longint'(done), 0);
    chk("R1", "on_cnt", on_cnt, 0);
    chk("R1", "off_cnt", off_cnt, 0);
    chk("R1", "achieved", achieved_khz, 0);
    chk("R1", "disable", longint'(mod_disable), 0);
    rst = 1'b0;

    // R3 R4 R5 R6 R2 vector walk
    foreach (VECS[k]) begin
      model(VECS[k][95:64], VECS[k][63:32], VECS[k][31:0]);
      launch(VECS[k][95:64], VECS[k][63:32], VECS[k][15:0]);
      wait_done("R3_R4");
      check_result("R3_R4");
    end

    // R4 tie: half speed must end on the 1/1 pair
    model(200000, 100000, 20);
    chk("R4", "tie on", e_on, 1);
    chk("R4", "tie off", e_off, 1);

    // R7 single pulse and hold; R8 second start ignored
    model(200000, 100000, 10);
    launch(32'd200000, 32'd100000, 16'd10);
    repeat (30) @(negedge clk);
    launch(32'd300000, 32'd1000, 16'd8);
    full_khz = 32'd7; target_khz = 32'd3;
    wait_done("R8");
    check_result("R8");
    @(negedge clk);
    chk("R7", "done low after pulse", longint'(done), 0);
    repeat (5) @(negedge clk);
    check_result("R7");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule